// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit holds the transmit and receive queues that sit between a processor-side register port and the serial shift engine of an SPI master. Software fills the transmit queue one word per write, and the engine takes words through a valid/take handshake. The engine deposits received words through a push/room handshake, and software drains them one word per read. A frame-done pulse from the engine latches a sticky completion flag.

Every status flag is computed against a programmable threshold. The transmit request flag tells software there is space worth refilling. The receive ready flag tells it there is enough data worth reading. Each flag has an enable bit, and the single interrupt line is the OR of the enabled flags. Software can also flush either queue, reset the whole unit, or gate the engine handshakes with a module enable. A read-only word reports both queue depths as base-2 exponents.

The register port uses word indices on `reg_addr`. Index 0 is the parameter word. Index 1 is control, index 2 is status and index 3 is the interrupt enables. Index 4 holds the watermarks and index 5 the queue counts. Index 6 is transmit data, index 7 is receive status and index 8 is receive data. Reads are combinational while `reg_rd` is high. Writes and pops take effect at the clock edge.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: A read of index 0 returns the transmit depth exponent in bits 3:0 and the receive depth exponent in bits 11:8, with every other bit zero (0x303 for two depths of 8).
- R2: A write to index 6 appends the word to the transmit queue unless the queue is full, in which case the word is dropped. Index 5 reports the transmit entry count in bits 7:0 and the receive count in bits 23:16.
- R3: `eng_tx_valid` is high while the module is enabled and the transmit queue is not empty. `eng_tx_data` shows the oldest word, and a cycle with both `eng_tx_valid` and `eng_tx_take` high removes that word.
- R4: `eng_rx_push` with `eng_rx_room` high appends `eng_rx_data`. A read of index 8 returns the oldest word and removes it. When the queue is empty, that read returns zero and removes nothing. Index 7 bit 1 is 1 exactly while the receive queue is empty.
- R5: Index 4 holds the transmit watermark in its low bits (3:0 by default) and the receive watermark from bit 16. Status (index 2) bit 0 is 1 while the transmit count is at or below the transmit watermark.
- R6: Status bit 1 is 1 while the receive count is strictly above the receive watermark.
- R7: Status bit 10 is set by an `eng_frame_done` pulse and stays set until index 2 is written with bit 10 equal to 1. Writing 0 there leaves it set, and a pulse in the same cycle as the clearing write wins.
- R8: Index 3 holds interrupt enables at the same bit positions as the status flags (0, 1, 10). `irq` is high exactly when some status flag and its enable are both 1.
- R9: Writing index 1 with bit 8 set empties the transmit queue, and writing it with bit 9 set empties the receive queue. These bits are not stored. Index 1 bit 0 is the module enable and reads back.
- R10: Writing index 1 with bit 1 set returns the unit to its reset state: enable, watermarks, interrupt enables and the completion flag become zero, and both queues become empty.
- R11: While the module enable is 0, `eng_tx_valid` and `eng_rx_room` are low and `eng_rx_push` leaves the receive queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at index 8) |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, zero when `reg_rd` is low |
| eng_tx_valid | output | 1 | Transmit word available to the engine |
| eng_tx_data | output | DATA_W | Oldest transmit word |
| eng_tx_take | input | 1 | Engine consumes the offered transmit word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DATA_W | Received word |
| eng_rx_room | output | 1 | Receive queue can accept a word |
| eng_frame_done | input | 1 | Pulse marking the end of a frame |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives the transmit queue to full and one word past it. A design that accepted that word would advance a pointer and corrupt the oldest entry the engine sees. Reads of the receive data index on an empty queue are aimed at designs that would return stale memory or let the count wrap below zero. Watermarks are set so that the counts sit exactly on the threshold and one entry beyond it, which exposes off-by-one compares in the request and ready flags. The bench also lines up frame-done pulses with clearing writes, flushes with concurrent pushes, and engine traffic with the module disabled, so that a wrong priority shows up as a stuck or lost flag or a miscounted queue.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

    typedef enum logic [3:0] {
        A_PARAM  = 4'd0,
        A_CTRL   = 4'd1,
        A_STAT   = 4'd2,
        A_IEN    = 4'd3,
        A_WMARK  = 4'd4,
        A_FCNT   = 4'd5,
        A_TXD    = 4'd6,
        A_RXSTAT = 4'd7,
        A_RXD    = 4'd8
    } reg_addr_e;

    // status / enable bit positions
    localparam int B_TXREQ = 0;
    localparam int B_RXRDY = 1;
    localparam int B_DONE  = 10;

    // control bit positions
    localparam int C_EN    = 0;
    localparam int C_SRST  = 1;
    localparam int C_TXFL  = 8;
    localparam int C_RXFL  = 9;

    localparam int RXS_EMPTY = 1;
    localparam int WM_RX_LSB = 16;
    localparam int FC_RX_LSB = 16;

    typedef struct packed {
        logic done;
        logic rxrdy;
        logic txreq;
    } flags_t;

    typedef struct packed {
        logic soft_rst;
        logic tx_flush;
        logic rx_flush;
    } ctrl_cmd_t;

    function automatic logic [31:0] flags_to_word(flags_t f);
        logic [31:0] w;
        w          = '0;
        w[B_TXREQ] = f.txreq;
        w[B_RXRDY] = f.rxrdy;
        w[B_DONE]  = f.done;
        return w;
    endfunction

    function automatic flags_t word_to_flags(logic [31:0] w);
        flags_t f;
        f.txreq = w[B_TXREQ];
        f.rxrdy = w[B_RXRDY];
        f.done  = w[B_DONE];
        return f;
    endfunction

    function automatic logic [31:0] param_word(int unsigned tl, int unsigned rl);
        logic [31:0] w;
        w       = '0;
        w[3:0]  = 4'(tl);
        w[11:8] = 4'(rl);
        return w;
    endfunction

endpackage

// File: rtl/sfu_fifo.sv
module sfu_fifo #(
    parameter int DW   = 32,
    parameter int LOG2 = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [LOG2:0] count,
    output logic          full,
    output logic          empty
);
    localparam int DEPTH = 1 << LOG2;
    localparam logic [LOG2:0] FULL_CNT = {1'b1, {LOG2{1'b0}}};

    logic [DW-1:0]   mem [DEPTH];
    logic [LOG2-1:0] wptr, rptr;
    logic            do_push, do_pop;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: occupancy never exceeds the depth
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    // R2: a push into a full queue leaves it full, not wrapped
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        full && push && !pop && !flush |=> full);

    // R4: a pop from an empty queue leaves it empty
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        empty && pop && !push |=> empty);

endmodule

// File: rtl/sfu_flags.sv
module sfu_flags
    import sfu_pkg::*;
#(
    parameter int TCW = 4,
    parameter int RCW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           soft_rst,
    input  logic [TCW-1:0] tx_cnt,
    input  logic [RCW-1:0] rx_cnt,
    input  logic [TCW-1:0] tx_wm,
    input  logic [RCW-1:0] rx_wm,
    input  logic           done_set,
    input  logic           done_clr,
    input  flags_t         ien,
    output flags_t         flags,
    output logic           irq
);
    logic done_q;

    always_ff @(posedge clk) begin
        if (rst || soft_rst)  done_q <= 1'b0;
        else if (done_set)    done_q <= 1'b1;
        else if (done_clr)    done_q <= 1'b0;
    end

    always_comb begin
        flags.txreq = (tx_cnt <= tx_wm);
        flags.rxrdy = (rx_cnt > rx_wm);
        flags.done  = done_q;
    end

    assign irq = (flags.txreq & ien.txreq) |
                 (flags.rxrdy & ien.rxrdy) |
                 (flags.done  & ien.done);

    // R7: completion flag is sticky until an explicit clear
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        done_q && !done_clr && !soft_rst |=> done_q);

    // R7: a frame-done pulse always lands, even against a clear
    assert_done_set_R7: assert property (@(posedge clk) disable iff (rst)
        done_set && !soft_rst |=> done_q);

endmodule

// File: rtl/sfu_regs.sv
module sfu_regs
    import sfu_pkg::*;
#(
    parameter int DW      = 32,
    parameter int TX_LOG2 = 3,
    parameter int RX_LOG2 = 3,
    localparam int TCW    = TX_LOG2 + 1,
    localparam int RCW    = RX_LOG2 + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_wr,
    input  logic           reg_rd,
    input  logic [3:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    input  flags_t         flags,
    input  logic [TCW-1:0] tx_cnt,
    input  logic [RCW-1:0] rx_cnt,
    input  logic           rx_empty,
    input  logic [DW-1:0]  rx_head,
    output logic           en,
    output logic [TCW-1:0] tx_wm,
    output logic [RCW-1:0] rx_wm,
    output flags_t         ien,
    output ctrl_cmd_t      cmd,
    output logic           tx_push,
    output logic           rx_pop,
    output logic           done_clr
);
    logic        wr_ctrl, wr_ien, wr_wm, wr_stat;
    logic [31:0] rd_word;
    logic        unused_wdata;

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_ien  = reg_wr && (reg_addr == A_IEN);
    assign wr_wm   = reg_wr && (reg_addr == A_WMARK);
    assign wr_stat = reg_wr && (reg_addr == A_STAT);

    assign cmd.soft_rst = wr_ctrl & reg_wdata[C_SRST];
    assign cmd.tx_flush = wr_ctrl & reg_wdata[C_TXFL];
    assign cmd.rx_flush = wr_ctrl & reg_wdata[C_RXFL];

    assign tx_push  = reg_wr && (reg_addr == A_TXD);
    assign rx_pop   = reg_rd && (reg_addr == A_RXD) && !rx_empty;
    assign done_clr = wr_stat & reg_wdata[B_DONE];

    assign unused_wdata = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (rst || cmd.soft_rst) begin
            en    <= 1'b0;
            tx_wm <= '0;
            rx_wm <= '0;
            ien   <= '0;
        end else begin
            if (wr_ctrl) en  <= reg_wdata[C_EN];
            if (wr_ien)  ien <= word_to_flags(reg_wdata);
            if (wr_wm) begin
                tx_wm <= reg_wdata[TCW-1:0];
                rx_wm <= reg_wdata[WM_RX_LSB +: RCW];
            end
        end
    end

    always_comb begin
        rd_word = '0;
        case (reg_addr_e'(reg_addr))
            A_PARAM:  rd_word = param_word(TX_LOG2, RX_LOG2);
            A_CTRL:   rd_word[C_EN] = en;
            A_STAT:   rd_word = flags_to_word(flags);
            A_IEN:    rd_word = flags_to_word(ien);
            A_WMARK: begin
                rd_word[TCW-1:0]           = tx_wm;
                rd_word[WM_RX_LSB +: RCW]  = rx_wm;
            end
            A_FCNT: begin
                rd_word[TCW-1:0]           = tx_cnt;
                rd_word[FC_RX_LSB +: RCW]  = rx_cnt;
            end
            A_RXSTAT: rd_word[RXS_EMPTY] = rx_empty;
            A_RXD:    if (!rx_empty) rd_word[DW-1:0] = rx_head;
            default:  rd_word = '0;
        endcase
    end

    assign reg_rdata = reg_rd ? rd_word : '0;

endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
    import sfu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int TX_LOG2 = 3,
    parameter int RX_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              eng_tx_valid,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_tx_take,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    output logic              eng_rx_room,
    input  logic              eng_frame_done,
    output logic              irq
);
    localparam int TCW = TX_LOG2 + 1;
    localparam int RCW = RX_LOG2 + 1;

    logic              en, tx_push, rx_pop, done_clr;
    logic [TCW-1:0]    tx_cnt, tx_wm;
    logic [RCW-1:0]    rx_cnt, rx_wm;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0] rx_head;
    flags_t            flags, ien;
    ctrl_cmd_t         cmd;

    assign eng_tx_valid = en & ~tx_empty;
    assign eng_rx_room  = en & ~rx_full;

    sfu_regs #(.DW(DATA_W), .TX_LOG2(TX_LOG2), .RX_LOG2(RX_LOG2)) u_regs (
        .clk, .rst, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
        .flags, .tx_cnt, .rx_cnt, .rx_empty, .rx_head,
        .en, .tx_wm, .rx_wm, .ien, .cmd, .tx_push, .rx_pop, .done_clr
    );

    sfu_fifo #(.DW(DATA_W), .LOG2(TX_LOG2)) u_txq (
        .clk, .rst,
        .flush (cmd.tx_flush | cmd.soft_rst),
        .push  (tx_push),
        .wdata (reg_wdata[DATA_W-1:0]),
        .pop   (eng_tx_take & eng_tx_valid),
        .rdata (eng_tx_data),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    sfu_fifo #(.DW(DATA_W), .LOG2(RX_LOG2)) u_rxq (
        .clk, .rst,
        .flush (cmd.rx_flush | cmd.soft_rst),
        .push  (eng_rx_push & eng_rx_room),
        .wdata (eng_rx_data),
        .pop   (rx_pop),
        .rdata (rx_head),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    sfu_flags #(.TCW(TCW), .RCW(RCW)) u_flags (
        .clk, .rst,
        .soft_rst (cmd.soft_rst),
        .tx_cnt, .rx_cnt, .tx_wm, .rx_wm,
        .done_set (eng_frame_done),
        .done_clr,
        .ien, .flags, .irq
    );

    // R9: transmit flush empties the queue on the next cycle
    assert_tx_flush_R9: assert property (@(posedge clk) disable iff (rst)
        reg_wr && reg_addr == A_CTRL && reg_wdata[C_TXFL] |=> tx_cnt == '0);

    // R9: receive flush empties the queue on the next cycle
    assert_rx_flush_R9: assert property (@(posedge clk) disable iff (rst)
        reg_wr && reg_addr == A_CTRL && reg_wdata[C_RXFL] |=> rx_cnt == '0);

    // R10: software reset clears state across all sub-blocks
    assert_soft_reset_R10: assert property (@(posedge clk) disable iff (rst)
        reg_wr && reg_addr == A_CTRL && reg_wdata[C_SRST]
        |=> !en && tx_cnt == '0 && rx_cnt == '0 && !flags.done && ien == '0);

    // R4: empty receive read returns zero
    assert_rx_empty_read_R4: assert property (@(posedge clk) disable iff (rst)
        reg_rd && reg_addr == A_RXD && rx_cnt == '0 |-> reg_rdata == '0);

    // R11: disabled module does not grow the receive queue
    assert_disabled_rx_R11: assert property (@(posedge clk) disable iff (rst)
        !en && eng_rx_push && !rx_pop |=> rx_cnt <= $past(rx_cnt));

endmodule

// File: tb/test_spi_fifo_irq_unit.sv
`timescale 1ns/1ps
module test_spi_fifo_irq_unit;
    localparam int DW   = 32;
    localparam int TXL  = 3;
    localparam int RXL  = 3;
    localparam int TDEP = 1 << TXL;
    localparam int RDEP = 1 << RXL;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic b_wr = 0, b_rd = 0, b_take = 0, b_push = 0, b_fdone = 0;
    logic [3:0]  b_addr = '0;
    logic [31:0] b_wdata = '0, b_rxd = '0;
    logic [31:0] reg_rdata;
    logic [DW-1:0] eng_tx_data;
    logic eng_tx_valid, eng_rx_room, irq;

    int n_chk = 0, n_fail = 0;

    logic [31:0] mtx[$];
    logic [31:0] mrx[$];
    logic        m_en, m_done;
    logic [3:0]  m_twm, m_rwm;
    logic [31:0] m_ien;

    always #2.5 clk = ~clk;

    spi_fifo_irq_unit #(.DATA_W(DW), .TX_LOG2(TXL), .RX_LOG2(RXL)) i_spi_fifo_irq_unit (
        .clk, .rst,
        .reg_wr(b_wr), .reg_rd(b_rd), .reg_addr(b_addr), .reg_wdata(b_wdata),
        .reg_rdata,
        .eng_tx_valid, .eng_tx_data, .eng_tx_take(b_take),
        .eng_rx_push(b_push), .eng_rx_data(b_rxd), .eng_rx_room,
        .eng_frame_done(b_fdone), .irq
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        mtx.delete(); mrx.delete();
        m_en = 0; m_done = 0; m_twm = 0; m_rwm = 0; m_ien = 0;
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] w = '0;
        w[0]  = (mtx.size() <= int'(m_twm));
        w[1]  = (mrx.size() > int'(m_rwm));
        w[10] = m_done;
        return w;
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        case (a)
            4'd0: return (32'(RXL) << 8) | 32'(TXL);
            4'd1: return {31'b0, m_en};
            4'd2: return exp_status();
            4'd3: return m_ien;
            4'd4: return {12'b0, m_rwm, 12'b0, m_twm};
            4'd5: return (32'(mrx.size()) << 16) | 32'(mtx.size());
            4'd7: return (mrx.size() == 0) ? 32'h2 : 32'h0;
            4'd8: return (mrx.size() > 0) ? mrx[0] : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0: return "R1";
            4'd1: return "R9";
            4'd2: return "R7";
            4'd3: return "R8";
            4'd4: return "R5";
            4'd5: return "R2";
            default: return "R4";
        endcase
    endfunction

    // one clock cycle: drive at negedge, check combinational outputs, update model at posedge
    task automatic cyc(input logic wr, input logic rd, input logic [3:0] a, input logic [31:0] wd,
                       input logic take, input logic push, input logic [31:0] rxd, input logic fd,
                       input bit kchk, input logic [31:0] kval, input string ktag);
        int ts, rs;
        logic [31:0] e;
        b_wr = wr; b_rd = rd; b_addr = a; b_wdata = wd;
        b_take = take; b_push = push; b_rxd = rxd; b_fdone = fd;
        #1;
        if (rd) begin
            e = exp_read(a);
            chk(reg_rdata == e, tag_of(a), reg_rdata, e);
            if (kchk) chk(reg_rdata == kval, ktag, reg_rdata, kval);
        end
        chk(eng_tx_valid == (m_en && mtx.size() > 0), "R3", {31'b0, eng_tx_valid}, {31'b0, m_en && mtx.size() > 0});
        if (eng_tx_valid && mtx.size() > 0) chk(eng_tx_data == mtx[0], "R3", eng_tx_data, mtx[0]);
        chk(eng_rx_room == (m_en && mrx.size() < RDEP), "R11", {31'b0, eng_rx_room}, {31'b0, m_en && mrx.size() < RDEP});
        chk(irq == |(exp_status() & m_ien), "R8", {31'b0, irq}, {31'b0, |(exp_status() & m_ien)});
        @(posedge clk);
        ts = mtx.size(); rs = mrx.size();
        if (wr && a == 4'd1 && wd[1]) begin
            model_reset();
        end else begin
            if (take && m_en && ts > 0) void'(mtx.pop_front());
            if (wr && a == 4'd6 && ts < TDEP) mtx.push_back(wd);
            if (wr && a == 4'd1 && wd[8]) mtx.delete();
            if (rd && a == 4'd8 && rs > 0) void'(mrx.pop_front());
            if (push && m_en && rs < RDEP) mrx.push_back(rxd);
            if (wr && a == 4'd1 && wd[9]) mrx.delete();
            if (fd) m_done = 1;
            else if (wr && a == 4'd2 && wd[10]) m_done = 0;
            if (wr && a == 4'd1) m_en = wd[0];
            if (wr && a == 4'd3) m_ien = wd & 32'h0000_0403;
            if (wr && a == 4'd4) begin m_twm = wd[3:0]; m_rwm = wd[19:16]; end
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cyc(1, 0, a, d, 0, 0, 0, 0, 0, 0, "");
    endtask
    task automatic rdk(input logic [3:0] a, input logic [31:0] k, input string tag);
        cyc(0, 1, a, 0, 0, 0, 0, 0, 1, k, tag);
    endtask
    task automatic epush(input logic [31:0] d);
        cyc(0, 0, 0, 0, 0, 1, d, 0, 0, 0, "");
    endtask
    task automatic etake();
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "");
    endtask
    task automatic fdone();
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "");
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_test();
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // reset state and parameter word
        rdk(4'd0, 32'h0000_0303, "R1");
        rdk(4'd2, 32'h0000_0001, "R5");
        rdk(4'd5, 32'h0, "R2");
        rdk(4'd7, 32'h2, "R4");
        chk(irq == 1'b0, "R8", {31'b0, irq}, 32'h0);

        // disabled: fill past full, engine push ignored
        for (int i = 0; i < TDEP + 1; i++) wr(4'd6, 32'h100 + 32'(i));
        rdk(4'd5, 32'h8, "R2");
        chk(eng_tx_valid == 1'b0, "R11", {31'b0, eng_tx_valid}, 32'h0);
        epush(32'hDEAD);
        rdk(4'd5, 32'h8, "R11");

        // enable and drain in order; dropped word never appears
        wr(4'd1, 32'h1);
        for (int i = 0; i < TDEP; i++) begin
            chk(eng_tx_data == 32'h100 + 32'(i), "R3", eng_tx_data, 32'h100 + 32'(i));
            etake();
        end
        chk(eng_tx_valid == 1'b0, "R3", {31'b0, eng_tx_valid}, 32'h0);

        // receive path and empty read
        for (int i = 0; i < 3; i++) epush(32'hA0 + 32'(i));
        rdk(4'd7, 32'h0, "R4");
        for (int i = 0; i < 3; i++) rdk(4'd8, 32'hA0 + 32'(i), "R4");
        rdk(4'd8, 32'h0, "R4");
        rdk(4'd5, 32'h0, "R4");
        rdk(4'd7, 32'h2, "R4");

        // watermark boundaries
        wr(4'd4, 32'h0001_0002);
        rdk(4'd4, 32'h0001_0002, "R5");
        wr(4'd6, 32'h11); wr(4'd6, 32'h12);
        rdk(4'd2, 32'h1, "R5");
        wr(4'd6, 32'h13);
        rdk(4'd2, 32'h0, "R5");
        epush(32'h21);
        rdk(4'd2, 32'h0, "R6");
        epush(32'h22);
        rdk(4'd2, 32'h2, "R6");

        // flushes
        wr(4'd1, 32'h101);
        rdk(4'd5, 32'h0002_0000, "R9");
        wr(4'd1, 32'h201);
        rdk(4'd5, 32'h0, "R9");
        rdk(4'd1, 32'h1, "R9");

        // completion flag and interrupt
        fdone();
        rdk(4'd2, 32'h401, "R7");
        wr(4'd2, 32'h0);
        rdk(4'd2, 32'h401, "R7");
        wr(4'd3, 32'h400);
        chk(irq == 1'b1, "R8", {31'b0, irq}, 32'h1);
        cyc(1, 0, 4'd2, 32'h400, 0, 0, 0, 1, 0, 0, "");
        rdk(4'd2, 32'h401, "R7");
        wr(4'd2, 32'h400);
        rdk(4'd2, 32'h1, "R7");
        chk(irq == 1'b0, "R8", {31'b0, irq}, 32'h0);

        // software reset
        wr(4'd3, 32'h403);
        wr(4'd6, 32'h55);
        epush(32'h66);
        fdone();
        wr(4'd1, 32'h3);
        rdk(4'd1, 32'h0, "R10");
        rdk(4'd3, 32'h0, "R10");
        rdk(4'd4, 32'h0, "R10");
        rdk(4'd5, 32'h0, "R10");
        rdk(4'd2, 32'h1, "R10");

        // constrained random phase
        void'($urandom(32'd20240611));
        wr(4'd1, 32'h1);
        for (int n = 0; n < 4000; n++) begin
            int op;
            logic w, r, tk, pu, fd;
            logic [3:0] a;
            logic [31:0] d;
            op = $urandom_range(0, 99);
            w  = (op < 35);
            r  = (op >= 35 && op < 60);
            d  = $urandom;
            if (w) begin
                case ($urandom_range(0, 6))
                    0: a = 4'd1;
                    1: a = 4'd2;
                    2: a = 4'd3;
                    3: a = 4'd4;
                    default: a = 4'd6;
                endcase
            end else begin
                a = 4'($urandom_range(0, 8));
            end
            if (a == 4'd1) begin
                d = '0;
                d[0] = ($urandom_range(0, 9) != 0);
                d[1] = ($urandom_range(0, 199) == 0);
                d[8] = ($urandom_range(0, 11) == 0);
                d[9] = ($urandom_range(0, 11) == 0);
            end
            if (a == 4'd4) d = (32'($urandom_range(0, 8)) << 16) | 32'($urandom_range(0, 8));
            tk = ($urandom_range(0, 2) == 0);
            pu = ($urandom_range(0, 2) == 0);
            fd = ($urandom_range(0, 19) == 0);
            cyc(w, r, a, d, tk, pu, $urandom, fd, 0, 0, "");
        end
        finish_test();
    end

endmodule